// File: doc/BRIEF.md
# I2S Master Transmitter with Word Select

This block is the transmit side of an I2S bus master. It takes audio samples one word at a time from a valid/ready stream, where the words alternate left, right, left, and so on. It drives the serial bit clock, the serial data line and the word-select line. All timing comes from one fast system clock. The bit clock runs at a quarter of that rate, so a system clock of four times the wanted bit rate gives the bit rate (256 to 3072 kbps in practice).

Word select comes from a wrapping counter of half-bit periods. The counter stops at a terminal count of 2*WORD_BITS-1, which is 31 for 16-bit words and 63 for 32-bit words. A toggle flop flips on every wrap, so each word follows the previous one with no idle bits. When `tx_en` rises, the block waits one bit period with the clock idle high and fetches the first sample during that time. It then starts the first word with word select going high and the MSB on the data line at the same falling clock edge.

Each later word is fetched during the last bit period of the word before it. If no sample has arrived by the word boundary, zeros go out and a sticky flag is set.

Top module: `i2s_tx_master`

## Requirements
- R1: After reset, and on the clock edge after `tx_en` is seen low, `sck` is 1 and `ws`, `sd` and `s_ready` are 0. `underflow` is 0 after reset.
- R2: While transmitting, `sck` has a period of exactly 4 system clocks: 2 low, then 2 high. There are no pauses between words.
- R3: Data goes out MSB first. `sd` changes only together with a falling edge of `sck`, so it is stable at every rising edge, where the receiver samples it.
- R4: `ws` = 1 marks a left word and `ws` = 0 marks a right word. Words alternate, and the first word after a start is left. `ws` changes at the same falling `sck` edge that presents the new word's MSB.
- R5: Each `ws` level lasts exactly WORD_BITS bit periods. WORD_BITS is a parameter, 16 or 32. The half-bit counter wraps at 2*WORD_BITS-1.
- R6: The edge that samples `tx_en` high starts a lead bit period with `sck` held high. `sck` first falls, with `ws` rising, on the fourth clock edge after that one.
- R7: `s_ready` is high only while no sample is held, and only during the lead period or during the last bit period (4 clocks) of the current word. Accepted samples are sent one per word, in the order accepted.
- R8: A sample accepted in the final clock of that window, the very cycle of the word boundary, is sent as the next word with no underflow.
- R9: If no sample is held or offered at a word boundary, that word is all zeros and `underflow` becomes 1. It stays 1 until reset.
- R10: Dropping `tx_en` stops the stream on the next edge, even at a word boundary, and discards a held sample. A restart begins with a left word taken from a newly accepted sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, four times the bit rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmit enable; its rise starts a stream, its fall stops it |
| s_valid | input | 1 | Sample offered |
| s_data | input | WORD_BITS | Sample word, sent MSB first |
| s_ready | output | 1 | Block accepts a sample this cycle |
| sck | output | 1 | Serial bit clock, idle high |
| sd | output | 1 | Serial data |
| ws | output | 1 | Word select: 1 left, 0 right |
| underflow | output | 1 | Sticky flag: a word went out without a sample |

## Verification
Two events can coincide. The fetch handshake can fall in the same cycle as the word boundary that loads the shifter, and so can the stop request. For the first case, the bench waits for `s_ready` to rise and then offers the sample only in the fourth cycle of the window. It judges the result by deserializing the next word on `sd` and by seeing that `underflow` stays low. For the second case, `tx_en` is dropped in the boundary cycle while a sample is held. The bench then expects idle levels on the next clock, and after a restart it expects a left word carrying the new sample, never the discarded one.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_RUN  = 2'd2
  } tx_state_e;

  // Terminal count of the half-bit counter for a given word width.
  function automatic int unsigned half_term(input int unsigned wbits);
    return 2 * wbits - 1;
  endfunction

  // Width needed to hold half-bit indices 0 .. half_term(wbits).
  function automatic int unsigned half_bits(input int unsigned wbits);
    return $clog2(2 * wbits);
  endfunction

  // Fetch window: the last bit period of a word (two half-bit slots).
  function automatic bit fetch_open(input int unsigned hb, input int unsigned term);
    return (hb + 1) >= term;
  endfunction

endpackage

// File: rtl/i2s_tx_pace.sv
// Half-bit enable: pulses every second system clock while active.
// Combined with bit 0 of the half-bit counter it yields a divide-by-four bit clock.
module i2s_tx_pace (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic half_tick
);
  logic sub_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sub_q <= 1'b0;
    else if (clr) sub_q <= 1'b0;
    else          sub_q <= ~sub_q;
  end

  assign half_tick = sub_q;
endmodule

// File: rtl/i2s_tx_wscnt.sv
// Increment-and-wrap half-bit counter with a word-select toggle flop.
module i2s_tx_wscnt
  import i2s_tx_pkg::*;
#(
  parameter int unsigned WORD_BITS = 16,
  localparam int unsigned TERM = half_term(WORD_BITS),
  localparam int unsigned HBW  = half_bits(WORD_BITS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           adv,
  input  logic           jump,
  output logic [HBW-1:0] hb,
  output logic           ws,
  output logic           wrap
);
  localparam logic [HBW-1:0] TERM_V = HBW'(TERM);

  logic [HBW-1:0] hb_q;
  logic           ws_q;

  assign wrap = adv && !jump && (hb_q == TERM_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hb_q <= '0;
      ws_q <= 1'b0;
    end else if (clr) begin
      hb_q <= '0;
      ws_q <= 1'b0;
    end else if (jump || wrap) begin
      hb_q <= '0;
      ws_q <= ~ws_q;
    end else if (adv) begin
      hb_q <= hb_q + 1'b1;
    end
  end

  assign hb = hb_q;
  assign ws = ws_q;
endmodule

// File: rtl/i2s_tx_shreg.sv
// MSB-first output shifter.
module i2s_tx_shreg #(
  parameter int unsigned WORD_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 load,
  input  logic [WORD_BITS-1:0] ld_val,
  input  logic                 shift,
  output logic                 msb
);
  logic [WORD_BITS-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (clr)   sh_q <= '0;
    else if (load)  sh_q <= ld_val;
    else if (shift) sh_q <= {sh_q[WORD_BITS-2:0], 1'b0};
  end

  assign msb = sh_q[WORD_BITS-1];
endmodule

// File: rtl/i2s_tx_fetch.sv
// One-word holding stage between the sample stream and the shifter,
// with the zero-fill choice and the sticky underflow flag.
module i2s_tx_fetch #(
  parameter int unsigned WORD_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 window,
  input  logic                 load,
  input  logic                 s_valid,
  input  logic [WORD_BITS-1:0] s_data,
  output logic                 s_ready,
  output logic [WORD_BITS-1:0] ld_val,
  output logic                 ld_empty,
  output logic                 underflow
);
  logic                 held_q;
  logic [WORD_BITS-1:0] hold_q;
  logic                 uf_q;
  logic                 accept;

  assign s_ready  = window && !held_q;
  assign accept   = s_valid && s_ready;
  assign ld_empty = !held_q && !accept;

  always_comb begin
    if (held_q)      ld_val = hold_q;
    else if (accept) ld_val = s_data;
    else             ld_val = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      hold_q <= '0;
    end else if (clr || load) begin
      held_q <= 1'b0;
    end else if (accept) begin
      held_q <= 1'b1;
      hold_q <= s_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 uf_q <= 1'b0;
    else if (load && ld_empty)  uf_q <= 1'b1;
  end

  assign underflow = uf_q;
endmodule

// File: rtl/i2s_tx_master.sv
module i2s_tx_master
  import i2s_tx_pkg::*;
#(
  parameter int unsigned WORD_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tx_en,
  input  logic                 s_valid,
  input  logic [WORD_BITS-1:0] s_data,
  output logic                 s_ready,
  output logic                 sck,
  output logic                 sd,
  output logic                 ws,
  output logic                 underflow
);
  localparam int unsigned TERM = half_term(WORD_BITS);
  localparam int unsigned HBW  = half_bits(WORD_BITS);

  tx_state_e st_q;

  // Named internal events, also observed by the checker.
  logic                 active;
  logic                 half_tick;
  logic                 lead_done;
  logic                 wrap;
  logic                 load_stb;
  logic                 load_empty;
  logic                 shift_stb;
  logic                 window;
  logic [HBW-1:0]       hb;
  logic                 ws_int;
  logic                 msb;
  logic [WORD_BITS-1:0] ld_val;

  assign active    = tx_en && (st_q != ST_IDLE);
  assign lead_done = tx_en && (st_q == ST_LEAD) && half_tick && hb[0];
  assign load_stb  = lead_done || wrap;
  assign shift_stb = tx_en && (st_q == ST_RUN) && half_tick && hb[0] && !wrap;
  assign window    = tx_en && ((st_q == ST_LEAD) ||
                               ((st_q == ST_RUN) && fetch_open(int'(hb), TERM)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      st_q <= ST_IDLE;
    else if (!tx_en) st_q <= ST_IDLE;
    else begin
      unique case (st_q)
        ST_IDLE: st_q <= ST_LEAD;
        ST_LEAD: if (lead_done) st_q <= ST_RUN;
        default: st_q <= ST_RUN;
      endcase
    end
  end

  i2s_tx_pace u_pace (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (!active),
    .half_tick (half_tick)
  );

  i2s_tx_wscnt #(.WORD_BITS(WORD_BITS)) u_wscnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!active),
    .adv   (active && half_tick),
    .jump  (lead_done),
    .hb    (hb),
    .ws    (ws_int),
    .wrap  (wrap)
  );

  i2s_tx_fetch #(.WORD_BITS(WORD_BITS)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (!active),
    .window    (window),
    .load      (load_stb),
    .s_valid   (s_valid),
    .s_data    (s_data),
    .s_ready   (s_ready),
    .ld_val    (ld_val),
    .ld_empty  (load_empty),
    .underflow (underflow)
  );

  i2s_tx_shreg #(.WORD_BITS(WORD_BITS)) u_shreg (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (!active),
    .load   (load_stb),
    .ld_val (ld_val),
    .shift  (shift_stb),
    .msb    (msb)
  );

  assign sck = (st_q == ST_RUN) ? hb[0] : 1'b1;
  assign sd  = (st_q == ST_RUN) && msb;
  assign ws  = ws_int;
endmodule

// File: rtl/i2s_tx_checks.sv
module i2s_tx_checks (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic s_ready,
  input logic sck,
  input logic sd,
  input logic ws,
  input logic underflow,
  input logic active,
  input logic load_stb,
  input logic load_empty
);
  p_idle_levels_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (sck && !ws && !sd && !s_ready));

  p_sck_high_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |=> sck);

  p_sck_low_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sck) && tx_en) |=> !sck);

  p_sd_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$stable(sd)) |-> $fell(sck));

  p_ws_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !$stable(ws)) |-> $fell(sck));

  p_load_flips_ws_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> !$stable(ws));

  p_empty_load_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && load_empty) |=> underflow);

  p_underflow_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);
endmodule

bind i2s_tx_master i2s_tx_checks u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_en      (tx_en),
  .s_ready    (s_ready),
  .sck        (sck),
  .sd         (sd),
  .ws         (ws),
  .underflow  (underflow),
  .active     (active),
  .load_stb   (load_stb),
  .load_empty (load_empty)
);

// File: tb/test_i2s_tx_master.sv
module test_i2s_tx_master;
  localparam int W          = 16;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [W-1:0] d;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tx_en = 1'b0;
  logic         s_valid = 1'b0;
  logic [W-1:0] s_data = '0;
  logic         s_ready, sck, sd, ws, underflow;

  int n_cmp = 0;
  int n_bad = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2s_tx_master #(.WORD_BITS(W)) i_i2s_tx_master (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .sck(sck), .sd(sd), .ws(ws), .underflow(underflow)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Driver: offer one sample; late=1 waits for the window and offers it in its 4th cycle.
  task automatic send(input logic [W-1:0] d, input bit late, input bit keep, input string tag);
    if (late) begin
      while (!s_ready) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(s_ready == 1'b1, "R7", "ready in 4th window cycle", s_ready, 1);
      s_valid = 1'b1; s_data = d;
    end else begin
      s_valid = 1'b1; s_data = d;
      while (!s_ready) @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    s_valid = 1'b0; s_data = '0;
    if (keep) q.push_back('{d: d, tag: tag});
  endtask

  // Monitor: deserialize at rising sck, seen from the falling system clock edge.
  logic [W-1:0] mon_sh;
  int  mon_bits, since, per_bad, ws_bad;
  bit  have_rise, exp_left, word_ws, sck_prev;

  always @(negedge clk) begin
    if (!rst_n || !tx_en) begin
      mon_bits = 0; have_rise = 0; exp_left = 1; since = 0;
      sck_prev = 1; per_bad = 0; ws_bad = 0;
    end else begin
      since++;
      if (sck && !sck_prev) begin
        if (have_rise && since != 4) per_bad++;
        have_rise = 1; since = 0;
        if (mon_bits == 0) word_ws = ws;
        else if (ws != word_ws) ws_bad++;
        mon_sh = {mon_sh[W-2:0], sd};
        mon_bits++;
        if (mon_bits == W) begin
          chk(per_bad == 0, "R2", "sck period not 4 clocks", per_bad, 0);
          chk(ws_bad == 0, "R5", "ws moved inside a word", ws_bad, 0);
          chk(word_ws == exp_left, "R4", "ws level of word", word_ws, exp_left);
          if (q.size() == 0) begin
            chk(1'b0, "R7", "word with no expected sample", mon_sh, 0);
          end else begin
            exp_t e;
            e = q.pop_front();
            chk(mon_sh == e.d, e.tag, "R3 deserialized word", mon_sh, e.d);
            if (e.tag == "R9") chk(underflow == 1'b1, "R9", "underflow flag", underflow, 1);
          end
          exp_left = !exp_left;
          mon_bits = 0; per_bad = 0; ws_bad = 0;
        end
      end
      sck_prev = sck;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sck == 1'b1, "R1", "reset sck", sck, 1);
    chk(ws == 1'b0, "R1", "reset ws", ws, 0);
    chk(sd == 1'b0, "R1", "reset sd", sd, 0);
    chk(s_ready == 1'b0, "R1", "reset s_ready", s_ready, 0);
    chk(underflow == 1'b0, "R1", "reset underflow", underflow, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Start: lead period, then main stream with prompt samples.
    tx_en = 1'b1;
    fork
      begin
        for (int k = 1; k <= 4; k++) begin
          @(negedge clk);
          chk(sck == 1'b1, "R6", "sck high in lead", sck, 1);
        end
        @(negedge clk);
        chk(sck == 1'b0, "R6", "first sck fall", sck, 0);
        chk(ws == 1'b1, "R6", "ws rises with first bit", ws, 1);
      end
      begin
        send(16'h8001, 0, 1, "R7");
        send(16'hFFFF, 0, 1, "R7");
        send(16'h0000, 0, 1, "R7");
        send(16'hA5A5, 0, 1, "R7");
        send(16'h7FFE, 0, 1, "R7");
        send(16'h1234, 0, 1, "R7");
      end
    join

    // Samples offered only in the boundary cycle.
    send(16'hC3C3, 1, 1, "R8");
    send(16'h0001, 1, 1, "R8");
    send(16'h8000, 1, 1, "R8");
    send(16'h5A5A, 1, 1, "R8");
    chk(underflow == 1'b0, "R8", "no underflow after late samples", underflow, 0);

    // Starve one word.
    while (!underflow) @(negedge clk);
    q.push_back('{d: '0, tag: "R9"});
    send(16'h0F0F, 0, 1, "R7");
    send(16'hF00D, 0, 1, "R7");

    // Hold one sample, then stop in the boundary cycle.
    send(16'hDEAD, 0, 0, "R10");
    @(negedge clk);
    @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk);
    chk(sck == 1'b1, "R10", "sck after stop", sck, 1);
    chk(ws == 1'b0, "R10", "ws after stop", ws, 0);
    chk(sd == 1'b0, "R10", "sd after stop", sd, 0);
    chk(s_ready == 1'b0, "R10", "s_ready after stop", s_ready, 0);
    chk(q.size() == 0, "R10", "words still pending at stop", q.size(), 0);
    chk(underflow == 1'b1, "R9", "underflow still set", underflow, 1);
    q.delete();
    repeat (3) @(negedge clk);

    // Restart: first word must be the new sample, on the left.
    tx_en = 1'b1;
    send(16'h1357, 0, 1, "R10");
    send(16'h2468, 0, 1, "R7");
    send(16'hBEEF, 0, 1, "R7");
    while (q.size() != 0) @(negedge clk);
    tx_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(underflow == 1'b1, "R9", "underflow sticky at end", underflow, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule